// File: doc/BRIEF.md
# Watchdog Timer with Locked Configuration

This block is a watchdog built around a 16-bit up-counter. A prescaler divides the system clock by one of two ratios, slow (16384) or fast (256). Each prescaler tick advances the counter. When the counter wraps past its top value, the block raises a one-cycle timeout request and reloads the counter. Software keeps the timeout away by pulsing the service input. A service reloads the counter from a programmable reload field.

Three registers sit behind a small register bus. A control register holds the reload field and a lock bit. A request register holds a stop request and a fast-rate request. A read-only status register shows the live stop and rate states and the current count. While the lock bit is 0, software may write new requests, but the watchdog keeps running on its old settings. The requests take effect only on the cycle the lock bit goes from 0 to 1. The control register takes masked writes, so single fields can be changed without a read-modify-write.

Top module: `wdt_locked`

## Requirements
- R1: The request register (address 1) takes writes only while the lock bit is 0. A write while the lock bit is 1 leaves it unchanged.
- R2: In the request register, bit 3 is the stop request (1 = stop, 0 = run) and bit 2 is the rate request (1 = divide by 256, 0 = divide by 16384). Other bits read as 0.
- R3: While the lock bit stays 0, the live status bits keep their values. Pending requests have no effect on counting.
- R4: When the lock bit rises, status bit 0 (stop) is loaded from the stop request and status bit 1 (fast rate) is loaded from the rate request. The status register is at address 2.
- R5: Counting from a service, the timeout appears after (65536 - reload) x 256 x 64 system clocks at the slow rate, or after (65536 - reload) x 256 system clocks at the fast rate.
- R6: After reset, every register reads 0. This means lock open, reload 0, slow rate, running and count 0.
- R7: A service reloads the counter with control register bits 31:16 (the reload field). The count reads back in status bits 31:16.
- R8: A write to the control register (address 0) changes only the bit positions whose mask bit is 1. Bit 0 is the lock bit.
- R9: On the wrap from 0xFFFF, the timeout output is high for exactly one cycle and the counter is reloaded with the reload field.
- R10: While the live stop status is 1, the counter and prescaler hold still and no timeout occurs.
- R11: A service, or a change of the live rate, restarts the prescaler. The first tick after either event therefore takes a full divide interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address for write and read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable for the control register |
| bus_rdata | output | 32 | Registered read data of the addressed register, valid one cycle after the address |
| svc | input | 1 | Service pulse, reloads the counter |
| timeout | output | 1 | One-cycle timeout request |

## Verification
The period is measured from a service to the timeout pulse for several pairs of reload value and rate. Reloads of 0xFFFF, 0xFFFE and 0xFFF0 at the fast rate show the linear dependence on the reload. The same reloads at the slow rate show the factor of 64 between the rates. One measurement starts after a partial prescaler interval, so an exact count shows that the service restarted the prescaler. Directed steps then check, through the read port, that locked writes are blocked, that requests stay pending while unlocked, that masked writes keep unmasked bits, and that a stop freezes the count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_REQ  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam int unsigned REQ_STOP_BIT = 3;
  localparam int unsigned REQ_FAST_BIT = 2;

  typedef struct packed {
    logic stop;
    logic fast;
  } wdt_mode_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  reload,
  output wdt_mode_t         live
);
  localparam int unsigned RL_LO = DATA_W - CNT_W;

  logic      lock_q, lock_d, lock_rise;
  logic [CNT_W-1:0] reload_q;
  wdt_mode_t req_q, live_q;
  logic      unused_bits;

  assign unused_bits = ^{wdata[RL_LO-1:REQ_STOP_BIT+1], wdata[1], wmask[RL_LO-1:1]};

  assign lock_d    = (wr && addr == A_CTRL) ? ((lock_q & ~wmask[0]) | (wdata[0] & wmask[0])) : lock_q;
  assign lock_rise = lock_d & ~lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 1'b0;
      reload_q <= '0;
      req_q    <= '0;
      live_q   <= '0;
      rdata    <= '0;
    end else begin
      lock_q <= lock_d;
      if (wr && addr == A_CTRL)
        reload_q <= (reload_q & ~wmask[DATA_W-1:RL_LO]) | (wdata[DATA_W-1:RL_LO] & wmask[DATA_W-1:RL_LO]);
      if (wr && addr == A_REQ && !lock_q) begin
        req_q.stop <= wdata[REQ_STOP_BIT];
        req_q.fast <= wdata[REQ_FAST_BIT];
      end
      if (lock_rise) live_q <= req_q;
      case (addr)
        A_CTRL:  rdata <= {reload_q, {(RL_LO-1){1'b0}}, lock_q};
        A_REQ:   rdata <= {{(DATA_W-REQ_STOP_BIT-1){1'b0}}, req_q.stop, req_q.fast, 2'b00};
        A_STAT:  rdata <= {count, {(RL_LO-2){1'b0}}, live_q.fast, live_q.stop};
        default: rdata <= '0;
      endcase
    end
  end

  assign reload = reload_q;
  assign live   = live_q;

  // R1: locked request register ignores writes
  a_r1_req_locked: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_REQ && lock_q) |=> $stable(req_q));
  // R3/R4: live status moves only on a rising lock bit
  a_r3_live_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(live_q) |-> $rose(lock_q));
  a_r4_live_copy: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> live_q == $past(req_q));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned SLOW_LOG2 = 14,
  parameter int unsigned FAST_LOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  input  logic clear,
  output logic tick
);
  localparam int unsigned PW = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;
  localparam logic [PW-1:0] SLOW_TOP = PW'((64'd1 << SLOW_LOG2) - 64'd1);
  localparam logic [PW-1:0] FAST_TOP = PW'((64'd1 << FAST_LOG2) - 64'd1);

  logic [PW-1:0] pre_q;
  logic          fast_q, chg;
  logic [PW-1:0] top;

  assign chg  = fast ^ fast_q;
  assign top  = fast ? FAST_TOP : SLOW_TOP;
  assign tick = run && !chg && !clear && (pre_q == top);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      fast_q <= fast;
      if (clear || chg)  pre_q <= '0;
      else if (run)      pre_q <= tick ? '0 : pre_q + 1'b1;
    end
  end

  // R11: restart gives no tick on the following cycle
  a_r11_restart: assert property (@(posedge clk) disable iff (rst)
    (clear || chg) |=> !tick);
  // R5: ticks are never back to back
  a_r5_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R10: a stopped prescaler holds its state
  a_r10_pre_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear && !chg) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             svc,
  input  logic             stop,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             timeout
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             to_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= 1'b0;
      if (svc) begin
        cnt_q <= reload;
      end else if (tick) begin
        if (cnt_q == TOP) begin
          cnt_q <= reload;
          to_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign count   = cnt_q;
  assign timeout = to_q;

  // R7: service loads the reload field
  a_r7_service: assert property (@(posedge clk) disable iff (rst)
    svc |=> cnt_q == $past(reload));
  // R9: single-cycle timeout with reload
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (rst)
    to_q |=> !to_q);
  a_r9_wrap_load: assert property (@(posedge clk) disable iff (rst)
    to_q |-> cnt_q == $past(reload));
  // R10: stopped watchdog raises no timeout and holds the count
  a_r10_no_timeout: assert property (@(posedge clk) disable iff (rst)
    (stop && !svc) |=> (!to_q && $stable(cnt_q)));
endmodule

// File: rtl/wdt_locked.sv
module wdt_locked
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SLOW_LOG2 = 14,
  parameter int unsigned FAST_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_wmask,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              svc,
  output logic              timeout
);
  logic [CNT_W-1:0] count, reload;
  wdt_mode_t        live;
  logic             tick;

  wdt_regs #(.CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .wmask(bus_wmask), .count(count), .rdata(bus_rdata), .reload(reload), .live(live)
  );

  wdt_prescaler #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) i_pre (
    .clk(clk), .rst(rst), .run(!live.stop), .fast(live.fast), .clear(svc), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .tick(tick), .svc(svc), .stop(live.stop),
    .reload(reload), .count(count), .timeout(timeout)
  );
endmodule

// File: tb/test_wdt_locked.sv
module test_wdt_locked;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_wmask = '0;
  logic [31:0] bus_rdata;
  logic        svc = 1'b0;
  logic        timeout;
  int checks = 0, errors = 0;
  bit done = 0;

  wdt_locked i_wdt_locked (.*);

  always #5 clk = ~clk;

  localparam int NV = 5;
  localparam logic [15:0] V_RELOAD [NV] = '{16'hFFFF, 16'hFFFE, 16'hFFF0, 16'hFFFF, 16'hFFFE};
  localparam bit          V_FAST   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam int          V_PER    [NV] = '{256, 512, 4096, 16384, 32768};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d; bus_wmask = m;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a;
    @(posedge clk); #1 v = bus_rdata;
  endtask

  task automatic set_mode(input logic [15:0] rl, input bit fast, input bit stop);
    wr(2'd0, 32'h0, 32'h1);
    wr(2'd1, {28'h0, stop, fast, 2'b00}, 32'h0);
    wr(2'd0, {rl, 16'h0001}, 32'hFFFF_0001);
  endtask

  task automatic measure(output int n);
    @(negedge clk); svc = 1'b1;
    @(posedge clk); #1 svc = 1'b0;
    n = 0;
    while (n < 40000) begin
      @(posedge clk); n++; #1;
      if (timeout) break;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6: reset state
    rd(2'd0, v); check("R6 ctrl", v, 32'h0);
    rd(2'd1, v); check("R6 req", v, 32'h0);
    rd(2'd2, v); check("R6 status", v, 32'h0);
    check("R6 timeout", {31'h0, timeout}, 32'h0);

    // R5/R9/R11: period table
    for (int i = 0; i < NV; i++) begin
      set_mode(V_RELOAD[i], V_FAST[i], 1'b0);
      @(negedge clk); svc = 1'b1; @(negedge clk); svc = 1'b0;
      repeat (100) @(negedge clk);  // partial prescaler interval, R11
      measure(n);
      check("R5 R11 period", n, V_PER[i]);
      @(posedge clk); #1;
      check("R9 pulse width", {31'h0, timeout}, 32'h0);
      rd(2'd2, v); check("R9 reload after wrap", {16'h0, v[31:16]}, {16'h0, V_RELOAD[i]});
    end

    // R8: masked writes to ctrl
    wr(2'd0, 32'hABCD_0000, 32'hFFFF_0000);
    rd(2'd0, v); check("R8 reload field", v, 32'hABCD_0001);
    wr(2'd0, 32'h0005_0000, 32'h000F_0000);
    rd(2'd0, v); check("R8 partial mask", v, 32'hABC5_0001);

    // R1: locked request register ignores writes
    wr(2'd1, 32'h0000_000C, 32'h0);
    rd(2'd1, v); check("R1 locked write", v, 32'h0);

    // R2/R3: pending requests while unlocked
    wr(2'd0, 32'h0, 32'h1);
    wr(2'd1, 32'hFFFF_FFFC, 32'h0);
    rd(2'd1, v); check("R2 request bits", v, 32'h0000_000C);
    rd(2'd2, v); check("R3 status held", {30'h0, v[1:0]}, 32'h0);

    // R4/R10: lock copies stop+fast, counter freezes
    wr(2'd0, 32'hFFFF_0001, 32'hFFFF_0001);
    rd(2'd2, v); check("R4 status copied", {30'h0, v[1:0]}, 32'h3);
    @(negedge clk); svc = 1'b1; @(negedge clk); svc = 1'b0;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      @(posedge clk); #1; if (timeout) n++;
    end
    check("R10 no timeout while stopped", n, 0);
    rd(2'd2, v); check("R10 count frozen", {16'h0, v[31:16]}, 32'h0000_FFFF);

    // R7: service loads reload, visible in status count
    set_mode(16'h1234, 1'b0, 1'b0);
    @(negedge clk); svc = 1'b1; @(negedge clk); svc = 1'b0;
    rd(2'd2, v); check("R7 count after service", {16'h0, v[31:16]}, 32'h0000_1234);
    finish_run();
  end
endmodule